// File: doc/BRIEF.md
# Byte-Interleaved Sample FIFO with Threshold Interrupt

This block holds 16-bit conversion results from an acquisition sequencer until a host collects them. Each result that the sequencer completes arrives with a one-cycle valid strobe. The block stores it as a low byte and a high byte in a first-in first-out store of 512 samples. The host reads the store one byte at a time through a two-address register port. A read at offset 0 gives the low byte of the oldest sample. A read at offset 1 gives its high byte and then retires that sample.

The block raises a level interrupt request for the host. In threshold mode, the request is raised once the stored sample count reaches or passes half of the capacity (256 samples). In per-sample mode, the request is raised on every stored sample. The request stays high until the host acknowledges it. Sticky error flags record a write into a full store and a read from an empty one. A clear strobe returns the whole block to its empty state.

Top module: `byte_sample_fifo`

## Requirements
- R1: After reset, irqOut, overflowFlag, underflowFlag and rdData are all 0 and the store is empty.
- R2: A read strobe with rdAddr=0 puts bits 7:0 of the oldest stored sample on rdData one cycle later. With rdAddr=1 it puts bits 15:8 there.
- R3: Only a read at rdAddr=1 retires the oldest sample. Any number of reads at rdAddr=0 keep returning the same low byte.
- R4: Samples come out in the order they were accepted, and the store holds up to 512 samples.
- R5: With fifoEnable=1 and irqEnable=1, irqOut rises on the clock edge where an accepted write brings the count to 256 or more. It stays low while the count is 255 or less.
- R6: Once irqOut is high, it stays high until an irqAck strobe. irqAck clears it on the next edge, unless an accepted write on that same edge raises it again.
- R7: While irqEnable=0, accepted writes never raise irqOut.
- R8: With fifoEnable=0 and irqEnable=1, every accepted write raises irqOut, whatever the count.
- R9: A write strobe while 512 samples are stored is dropped and sets overflowFlag. The flag stays set until fifoReset. Stored contents are unchanged.
- R10: A read strobe while the store is empty gives rdData=0 on the next cycle and sets underflowFlag. The flag stays set until fifoReset. No sample is retired.
- R11: A fifoReset strobe empties the store and clears irqOut, overflowFlag and underflowFlag on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | One-cycle strobe: a conversion result is ready |
| sampleData | input | 16 | Conversion result |
| fifoEnable | input | 1 | 1: threshold interrupt mode, 0: per-sample interrupt mode |
| irqEnable | input | 1 | Allows interrupt requests to be raised |
| rdStrobe | input | 1 | Host byte read strobe |
| rdAddr | input | 1 | Byte offset: 0 is the low byte, 1 is the high byte (retires the sample) |
| rdData | output | 8 | Byte returned one cycle after rdStrobe |
| irqAck | input | 1 | Clears a pending interrupt request |
| fifoReset | input | 1 | Empties the store and clears the flags and the request |
| irqOut | output | 1 | Pending interrupt request |
| overflowFlag | output | 1 | Sticky: a write was dropped because the store was full |
| underflowFlag | output | 1 | Sticky: a read hit an empty store |

## Verification
The hardest state to reach is a completely full store, because only then can a dropped write be observed. The stimulus first pushes 256 samples to cross the interrupt threshold. It then pushes 256 more and sends one extra write while the store is full. After that it drains all 512 samples and checks them against a scoreboard model, which confirms that the extra write left no trace. Finally, one more read runs into the empty store. That read checks the zero result and the underflow flag, and then the clear strobe is checked.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // Strobes passed from the control path to the storage datapath
  typedef struct packed {
    logic push;     // store sampleData at the write pointer
    logic loadRd;   // capture a byte into the read register
    logic selHigh;  // choose upper byte of the head sample
    logic zeroOut;  // store empty: return zero
  } ctrl_strobes_t;
endpackage

// File: rtl/sfifo_datapath.sv
module sfifo_datapath
  import sfifo_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 512,
  localparam int SAMPLE_W = 2 * BYTE_W,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobes_t       strobes,
  input  logic [AW-1:0]       wrPtr,
  input  logic [AW-1:0]       rdPtr,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic [BYTE_W-1:0]   rdData
);
  logic [SAMPLE_W-1:0] sampleMem [DEPTH];
  logic [SAMPLE_W-1:0] headWord;

  always_ff @(posedge clk) begin
    if (strobes.push) sampleMem[wrPtr] <= sampleData;
  end

  assign headWord = sampleMem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.loadRd) begin
      if (strobes.zeroOut)      rdData <= '0;
      else if (strobes.selHigh) rdData <= headWord[SAMPLE_W-1:BYTE_W];
      else                      rdData <= headWord[BYTE_W-1:0];
    end
  end

  AST_PUSH_NOT_ON_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRd && strobes.zeroOut |=> rdData == '0) else $error("empty read not zero"); // R10
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int THRESH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleValid,
  input  logic          rdStrobe,
  input  logic          rdAddr,
  input  logic          fifoEnable,
  input  logic          irqEnable,
  input  logic          irqAck,
  input  logic          fifoReset,
  output ctrl_strobes_t strobes,
  output logic [AW-1:0] wrPtr,
  output logic [AW-1:0] rdPtr,
  output logic          irqOut,
  output logic          overflowFlag,
  output logic          underflowFlag
);
  localparam logic [CW-1:0] FULL_C   = CW'(DEPTH);
  localparam logic [CW-1:0] THRESH_C = CW'(THRESH);
  localparam logic [AW-1:0] LAST_C   = AW'(DEPTH - 1);

  logic [CW-1:0] count;
  logic [CW-1:0] countAfter;
  logic          isFull;
  logic          isEmpty;
  logic          pushOk;
  logic          popOk;
  logic          irqSet;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == LAST_C) ? '0 : p + 1'b1;
  endfunction

  assign isFull  = (count == FULL_C);
  assign isEmpty = (count == '0);
  assign pushOk  = sampleValid && !isFull && !fifoReset;
  assign popOk   = rdStrobe && rdAddr && !isEmpty && !fifoReset;
  assign countAfter = count + CW'(pushOk) - CW'(popOk);
  assign irqSet  = irqEnable && pushOk && (!fifoEnable || countAfter >= THRESH_C);

  always_comb begin
    strobes.push    = pushOk;
    strobes.loadRd  = rdStrobe;
    strobes.selHigh = rdAddr;
    strobes.zeroOut = isEmpty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (fifoReset) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      count <= countAfter;
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
      irqOut        <= 1'b0;
    end else if (fifoReset) begin
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
      irqOut        <= 1'b0;
    end else begin
      if (sampleValid && isFull) overflowFlag  <= 1'b1;
      if (rdStrobe && isEmpty)   underflowFlag <= 1'b1;
      if (irqSet)                irqOut <= 1'b1;
      else if (irqAck)           irqOut <= 1'b0;
    end
  end

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_C) else $error("count beyond capacity"); // R4
  AST_NO_OVERFLOW_STORE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && isFull && !fifoReset |=> overflowFlag) else $error("overflow not flagged"); // R9
  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && isEmpty && !fifoReset |=> underflowFlag) else $error("underflow not flagged"); // R10
  AST_THRESH_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    fifoEnable && irqEnable && sampleValid && !fifoReset && count == THRESH_C - 1'b1
      && !(rdStrobe && rdAddr) |=> irqOut) else $error("threshold irq missing"); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    irqOut && !irqAck && !fifoReset |=> irqOut) else $error("irq dropped early"); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(irqEnable)) else $error("irq without enable"); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    fifoReset |=> count == '0 && !irqOut && !overflowFlag && !underflowFlag)
    else $error("reset strobe incomplete"); // R11
endmodule

// File: rtl/byte_sample_fifo.sv
module byte_sample_fifo
  import sfifo_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 512,
  parameter int THRESH = 256,
  localparam int SAMPLE_W = 2 * BYTE_W,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                fifoEnable,
  input  logic                irqEnable,
  input  logic                rdStrobe,
  input  logic                rdAddr,
  output logic [BYTE_W-1:0]   rdData,
  input  logic                irqAck,
  input  logic                fifoReset,
  output logic                irqOut,
  output logic                overflowFlag,
  output logic                underflowFlag
);
  ctrl_strobes_t strobes;
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;

  sfifo_ctrl #(.DEPTH(DEPTH), .THRESH(THRESH)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .rdStrobe(rdStrobe),
    .rdAddr(rdAddr), .fifoEnable(fifoEnable), .irqEnable(irqEnable),
    .irqAck(irqAck), .fifoReset(fifoReset), .strobes(strobes),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .irqOut(irqOut),
    .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
  );

  sfifo_datapath #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .sampleData(sampleData), .rdData(rdData)
  );
endmodule

// File: tb/tb_byte_sample_fifo.sv
module tb_byte_sample_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 512;
  localparam int THRESH = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [15:0] sampleData = '0;
  logic fifoEnable = 1'b0;
  logic irqEnable = 1'b0;
  logic rdStrobe = 1'b0;
  logic rdAddr = 1'b0;
  logic [7:0] rdData;
  logic irqAck = 1'b0;
  logic fifoReset = 1'b0;
  logic irqOut, overflowFlag, underflowFlag;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic rdLat = 1'b0;
  logic [15:0] modelQ[$];
  int expQ[$];
  string tagQ[$];

  byte_sample_fifo dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .fifoEnable(fifoEnable), .irqEnable(irqEnable), .rdStrobe(rdStrobe),
    .rdAddr(rdAddr), .rdData(rdData), .irqAck(irqAck), .fifoReset(fifoReset),
    .irqOut(irqOut), .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compares each returned byte with the scoreboard
  always @(posedge clk) rdLat <= rdStrobe;
  always @(negedge clk) begin
    if (rdLat) begin
      if (expQ.size() == 0) check(1'b0, "scoreboard underrun", int'(rdData), 0);
      else begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(int'(rdData) == e, t, int'(rdData), e);
      end
    end
  end

  task automatic pushSample(input logic [15:0] d);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleData = d;
    if (modelQ.size() < DEPTH) modelQ.push_back(d);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  // Driver: issues one byte read and queues the expected byte
  task automatic readByte(input logic a, input string tag);
    int e;
    @(negedge clk);
    rdStrobe = 1'b1;
    rdAddr = a;
    if (modelQ.size() == 0) e = 0;
    else if (a) e = int'(modelQ[0][15:8]);
    else e = int'(modelQ[0][7:0]);
    if (a && modelQ.size() != 0) void'(modelQ.pop_front());
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  task automatic pulseReset();
    @(negedge clk); fifoReset = 1'b1;
    modelQ.delete();
    @(negedge clk); fifoReset = 1'b0;
  endtask

  function automatic logic [15:0] pattern(input int i);
    return 16'(16'hA55A ^ (i * 16'd37) ^ (i << 9));
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(irqOut == 0, "R1 irq", irqOut, 0);
    check(overflowFlag == 0 && underflowFlag == 0, "R1 flags", {overflowFlag, underflowFlag}, 0);
    check(rdData == 0, "R1 rdData", rdData, 0);

    // R2 R4 R7: basic order and byte selection, interrupts disabled
    pushSample(16'h1234);
    pushSample(16'hBEEF);
    pushSample(16'h00FF);
    check(irqOut == 0, "R7 no irq when disabled", irqOut, 0);
    readByte(1'b0, "R2 low byte");
    readByte(1'b0, "R3 repeated low byte");
    readByte(1'b0, "R3 repeated low byte");
    readByte(1'b1, "R2 high byte");
    for (int i = 0; i < 2; i++) begin
      readByte(1'b0, "R4 order low");
      readByte(1'b1, "R4 order high");
    end
    check(underflowFlag == 0, "R3 no underflow", underflowFlag, 0);

    // R5 R6 threshold interrupt
    fifoEnable = 1'b1;
    irqEnable = 1'b1;
    for (int i = 0; i < THRESH - 1; i++) pushSample(pattern(i));
    check(irqOut == 0, "R5 below threshold", irqOut, 0);
    pushSample(pattern(THRESH - 1));
    check(irqOut == 1, "R5 at threshold", irqOut, 1);
    repeat (5) @(negedge clk);
    check(irqOut == 1, "R6 held pending", irqOut, 1);
    pulseAck();
    check(irqOut == 0, "R6 cleared by ack", irqOut, 0);

    // R9 fill to capacity, then one dropped write
    irqEnable = 1'b0;
    for (int i = THRESH; i < DEPTH; i++) pushSample(pattern(i));
    check(overflowFlag == 0, "R9 no overflow at exactly full", overflowFlag, 0);
    pushSample(16'hDEAD);
    check(overflowFlag == 1, "R9 overflow set", overflowFlag, 1);
    check(irqOut == 0, "R7 no irq when disabled above threshold", irqOut, 0);
    for (int i = 0; i < DEPTH; i++) begin
      readByte(1'b0, "R4 R9 drain low");
      readByte(1'b1, "R4 R9 drain high");
    end
    check(overflowFlag == 1, "R9 overflow sticky", overflowFlag, 1);
    check(underflowFlag == 0, "R10 no underflow yet", underflowFlag, 0);

    // R10 empty read
    readByte(1'b1, "R10 empty returns zero");
    check(underflowFlag == 1, "R10 underflow set", underflowFlag, 1);
    pushSample(16'h5AC3);
    readByte(1'b0, "R10 nothing retired low");
    readByte(1'b1, "R10 nothing retired high");

    // R11 clear strobe
    irqEnable = 1'b1;
    fifoEnable = 1'b0;
    pushSample(16'h7777);
    check(irqOut == 1, "R8 per-sample irq", irqOut, 1);
    pulseReset();
    check(irqOut == 0, "R11 irq cleared", irqOut, 0);
    check(overflowFlag == 0 && underflowFlag == 0, "R11 flags cleared",
          {overflowFlag, underflowFlag}, 0);
    readByte(1'b0, "R11 store empty");
    check(underflowFlag == 1, "R11 empty after reset", underflowFlag, 1);
    pulseReset();

    // R8 per-sample mode raises on each write
    pushSample(16'h0102);
    check(irqOut == 1, "R8 first write", irqOut, 1);
    pulseAck();
    check(irqOut == 0, "R8 ack", irqOut, 0);
    pushSample(16'h0304);
    check(irqOut == 1, "R8 second write", irqOut, 1);
    readByte(1'b0, "R8 data low");
    readByte(1'b1, "R8 data high");
    readByte(1'b0, "R8 data low 2");
    readByte(1'b1, "R8 data high 2");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    finishRun();
  end
endmodule